// File: doc/BRIEF.md
# Full-Bridge Boundary-Mode Gate Sequencer

This block turns per-cycle timing numbers into the four gate commands of a single-phase full-bridge inverter that runs in boundary current mode. One leg is a fast, complementary pair that switches every cycle. The other leg is a slow pair that only follows the sign of the output voltage. An upstream calculator supplies an on-time and an off-time for each switching period, plus a dead time. All three are counted in ticks of the block clock. The block inserts a dead-time gap, with both fast gates low, after each of the two fast-pair transitions.

Each period runs in four phases: on, dead, off, dead. A period boundary falls at the end of the second dead gap. At a boundary the block takes up any timing values offered since the previous boundary, together with the current polarity and bridge-off requests. It also pulses `cycle_start` so the calculator can prepare the next pair of values. While the bridge-off request is latched, each period is a blanking slot of one dead time with every gate low. This is used near zero crossings of the output.

A one-tick `sample_trig` pulse marks the falling edge of the fast gate that closes the off phase. Downstream current sampling can use it to catch the reverse current.

Top module: `fb_gate_sequencer`

## Requirements
- R1: While `rst` is high, all four gate outputs, `cycle_start` and `sample_trig` are low.
- R2: A non-blank period is a sequence of phases with these lengths, in this order: on for max(on,1) ticks, dead for max(dead,1) ticks, off for max(off,1) ticks, dead for max(dead,1) ticks. A programmed zero therefore counts as one tick.
- R3: Positive polarity (`polarity_neg`=0) sets `gate_sa`=1 and `gate_sb`=0 for the whole period. `gate_fb` is high during the on phase and `gate_fa` is high during the off phase.
- R4: Negative polarity (`polarity_neg`=1) sets `gate_sb`=1 and `gate_sa`=0 for the whole period. `gate_fa` is high during the on phase and `gate_fb` is high during the off phase.
- R5: `gate_fa` and `gate_fb` are never high together. When either of them falls, the other stays low for the following dead gap.
- R6: `sample_trig` is high for exactly the first tick of the second dead gap. That is the tick in which `gate_fa` (positive polarity) or `gate_fb` (negative polarity) has just fallen.
- R7: If `bridge_off_req` is high at a boundary, the following period is a blanking slot of max(dead,1) ticks with all four gates and `sample_trig` low.
- R8: A value set is captured when `times_load` is high and used from the next boundary on. If no load occurs before a boundary, the previous values are reused, and changes on `on_ticks`, `off_ticks` and `dead_ticks` without `times_load` have no effect.
- R9: `polarity_neg` and `bridge_off_req` are sampled only at a boundary. Changing them mid-period does not alter the gates.
- R10: `cycle_start` is high for exactly the first tick of every period, blanking slots included.
- R11: `gate_sa` and `gate_sb` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock; one tick per edge |
| rst | input | 1 | Synchronous active-high reset |
| on_ticks | input | 16 | Requested on-phase length in ticks |
| off_ticks | input | 16 | Requested off-phase length in ticks |
| dead_ticks | input | 16 | Requested dead-gap length in ticks |
| times_load | input | 1 | Captures the three timing values |
| polarity_neg | input | 1 | 1 selects negative output polarity |
| bridge_off_req | input | 1 | Requests blanking slots with all gates low |
| gate_fa | output | 1 | Fast-leg switch 1 command |
| gate_fb | output | 1 | Fast-leg switch 2 command |
| gate_sa | output | 1 | Slow-leg switch 3 command |
| gate_sb | output | 1 | Slow-leg switch 4 command |
| cycle_start | output | 1 | One-tick strobe at the start of each period |
| sample_trig | output | 1 | One-tick strobe at the closing fast-gate fall |

## Verification
The bench builds the block with the package default of 16-bit tick counters. It programs small counts between 0 and 12, so that every phase and every whole period can be compared tick by tick. Zero counts reach the one-tick clamp, and the shortest non-blank period is six ticks. Dead gaps of two to five ticks and blanking slots of two and three ticks bring back-to-back boundaries within reach. The bench also applies polarity flips, bridge-off flips and unloaded changes to the timing inputs in the middle of periods.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    localparam int TW = 16;

    typedef logic [TW-1:0] tick_t;

    typedef enum logic [2:0] {
        PH_BLANK = 3'd0,
        PH_ON    = 3'd1,
        PH_DT1   = 3'd2,
        PH_OFF   = 3'd3,
        PH_DT2   = 3'd4
    } phase_e;

    typedef struct packed {
        tick_t on_t;
        tick_t off_t;
        tick_t dead_t;
    } times_s;

    typedef struct packed {
        logic neg;
        logic blank;
    } mode_s;

    typedef struct packed {
        logic fa;
        logic fb;
        logic sa;
        logic sb;
    } gates_s;

    // Counter preload for a phase of n ticks; zero is treated as one tick.
    function automatic tick_t last_tick(tick_t n);
        return (n == '0) ? '0 : tick_t'(n - tick_t'(1));
    endfunction

endpackage

// File: rtl/fbg_timing_shadow.sv
module fbg_timing_shadow
    import fbg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_en,
    input  times_s new_times,
    input  logic   boundary,
    input  logic   neg_req,
    input  logic   blank_req,
    output times_s fresh,
    output times_s act,
    output mode_s  mode
);

    times_s held;

    always_comb begin
        fresh = load_en ? new_times : held;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            act  <= '0;
            mode <= '{neg: 1'b0, blank: 1'b1};
        end else begin
            held <= fresh;
            if (boundary) begin
                act  <= fresh;
                mode <= '{neg: neg_req, blank: blank_req};
            end
        end
    end

    AST_TIMES_HOLD: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(act)) else $error("active times moved mid-period"); // R8

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(mode)) else $error("mode moved mid-period"); // R9

endmodule

// File: rtl/fbg_phase_seq.sv
module fbg_phase_seq
    import fbg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  times_s cur,
    input  times_s nxt,
    input  logic   nxt_blank,
    output phase_e phase,
    output logic   boundary,
    output logic   cycle_start,
    output logic   trig
);

    tick_t  cnt;
    tick_t  cnt_d;
    phase_e phase_d;
    logic   done;

    always_comb begin
        done     = (cnt == '0);
        boundary = done && (phase == PH_BLANK || phase == PH_DT2);
        phase_d  = phase;
        cnt_d    = tick_t'(cnt - tick_t'(1));
        if (done) begin
            unique case (phase)
                PH_ON: begin
                    phase_d = PH_DT1;
                    cnt_d   = last_tick(cur.dead_t);
                end
                PH_DT1: begin
                    phase_d = PH_OFF;
                    cnt_d   = last_tick(cur.off_t);
                end
                PH_OFF: begin
                    phase_d = PH_DT2;
                    cnt_d   = last_tick(cur.dead_t);
                end
                default: begin
                    if (nxt_blank) begin
                        phase_d = PH_BLANK;
                        cnt_d   = last_tick(nxt.dead_t);
                    end else begin
                        phase_d = PH_ON;
                        cnt_d   = last_tick(nxt.on_t);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_BLANK;
            cnt         <= '0;
            cycle_start <= 1'b0;
            trig        <= 1'b0;
        end else begin
            phase       <= phase_d;
            cnt         <= cnt_d;
            cycle_start <= boundary;
            trig        <= (phase == PH_OFF) && done;
        end
    end

    AST_START_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        cycle_start |-> (phase == PH_ON || phase == PH_BLANK)) else $error("start strobe outside period entry"); // R10

    AST_TRIG_IN_GAP: assert property (@(posedge clk) disable iff (rst)
        trig |-> (phase == PH_DT2)) else $error("trigger outside closing gap"); // R6

    AST_BOUNDARY_ROUTE: assert property (@(posedge clk) disable iff (rst)
        $past(phase == PH_OFF) && (phase != PH_OFF) |-> (phase == PH_DT2)) else $error("off phase not followed by gap"); // R2

endmodule

// File: rtl/fbg_gate_map.sv
module fbg_gate_map
    import fbg_pkg::*;
(
    input  phase_e phase,
    input  mode_s  mode,
    output gates_s gates
);

    logic drv_on;
    logic drv_off;

    always_comb begin
        drv_on  = (phase == PH_ON);
        drv_off = (phase == PH_OFF);
        gates   = '0;
        if (!mode.blank) begin
            if (mode.neg) begin
                gates.fa = drv_on;
                gates.fb = drv_off;
                gates.sb = 1'b1;
            end else begin
                gates.fb = drv_on;
                gates.fa = drv_off;
                gates.sa = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fb_gate_sequencer.sv
module fb_gate_sequencer
    import fbg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] on_ticks,
    input  logic [TW-1:0] off_ticks,
    input  logic [TW-1:0] dead_ticks,
    input  logic          times_load,
    input  logic          polarity_neg,
    input  logic          bridge_off_req,
    output logic          gate_fa,
    output logic          gate_fb,
    output logic          gate_sa,
    output logic          gate_sb,
    output logic          cycle_start,
    output logic          sample_trig
);

    times_s in_times;
    times_s fresh;
    times_s act;
    mode_s  mode;
    phase_e phase;
    logic   boundary;
    gates_s gates;

    always_comb begin
        in_times = '{on_t: on_ticks, off_t: off_ticks, dead_t: dead_ticks};
    end

    fbg_timing_shadow u_shadow (
        .clk       (clk),
        .rst       (rst),
        .load_en   (times_load),
        .new_times (in_times),
        .boundary  (boundary),
        .neg_req   (polarity_neg),
        .blank_req (bridge_off_req),
        .fresh     (fresh),
        .act       (act),
        .mode      (mode)
    );

    fbg_phase_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .cur         (act),
        .nxt         (fresh),
        .nxt_blank   (bridge_off_req),
        .phase       (phase),
        .boundary    (boundary),
        .cycle_start (cycle_start),
        .trig        (sample_trig)
    );

    fbg_gate_map u_map (
        .phase (phase),
        .mode  (mode),
        .gates (gates)
    );

    always_comb begin
        gate_fa = gates.fa;
        gate_fb = gates.fb;
        gate_sa = gates.sa;
        gate_sb = gates.sb;
    end

    AST_FAST_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(gate_fa && gate_fb)) else $error("fast pair overlap"); // R5

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
        ($fell(gate_fa) |-> !gate_fb) and ($fell(gate_fb) |-> !gate_fa)) else $error("no gap after fast fall"); // R5

    AST_SLOW_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(gate_sa && gate_sb)) else $error("slow pair overlap"); // R11

    AST_TRIG_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        sample_trig |-> (!gate_fa && !gate_fb && (mode.neg ? $past(gate_fb) : $past(gate_fa))))
        else $error("trigger not at closing fall"); // R6

    AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (rst)
        mode.blank |-> !sample_trig) else $error("trigger during blanking"); // R7

endmodule

// File: tb/fb_gate_sequencer_tb.sv
module fb_gate_sequencer_tb_top;

    localparam int NCYC = 14;

    typedef struct {
        int on_l;
        int off_l;
        int dead_l;
        bit neg;
        bit blank;
    } desc_s;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] on_ticks = '0;
    logic [15:0] off_ticks = '0;
    logic [15:0] dead_ticks = '0;
    logic        times_load = 1'b0;
    logic        polarity_neg = 1'b0;
    logic        bridge_off_req = 1'b0;
    logic        gate_fa, gate_fb, gate_sa, gate_sb;
    logic        cycle_start, sample_trig;

    int  checks = 0;
    int  failures = 0;
    bit  mon_done = 1'b0;
    desc_s q[$];

    int  p_on[NCYC];
    int  p_off[NCYC];
    int  p_dead[NCYC];
    bit  p_neg[NCYC];
    bit  p_blank[NCYC];
    bit  p_load[NCYC];

    always #4 clk = ~clk;

    fb_gate_sequencer dut_i (
        .clk            (clk),
        .rst            (rst),
        .on_ticks       (on_ticks),
        .off_ticks      (off_ticks),
        .dead_ticks     (dead_ticks),
        .times_load     (times_load),
        .polarity_neg   (polarity_neg),
        .bridge_off_req (bridge_off_req),
        .gate_fa        (gate_fa),
        .gate_fb        (gate_fb),
        .gate_sa        (gate_sa),
        .gate_sb        (gate_sb),
        .cycle_start    (cycle_start),
        .sample_trig    (sample_trig)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int clamp1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    task automatic set_plan(input int i, input int on, input int off, input int dead,
                            input bit neg, input bit blank, input bit load);
        p_on[i] = on; p_off[i] = off; p_dead[i] = dead;
        p_neg[i] = neg; p_blank[i] = blank; p_load[i] = load;
    endtask

    // Driver: applies inputs for period i during period i-1 and pushes the expectation.
    desc_s eff;
    task automatic apply(input int i);
        desc_s d;
        if (p_load[i]) begin
            on_ticks = 16'(p_on[i]); off_ticks = 16'(p_off[i]); dead_ticks = 16'(p_dead[i]);
            times_load = 1'b1;
            eff.on_l = clamp1(p_on[i]); eff.off_l = clamp1(p_off[i]); eff.dead_l = clamp1(p_dead[i]); // R2 zero clamp
        end else begin
            // R8: unloaded changes must be ignored, previous values reused
            on_ticks = 16'h00F3; off_ticks = 16'h0011; dead_ticks = 16'h0029;
            times_load = 1'b0;
        end
        polarity_neg = p_neg[i];
        bridge_off_req = p_blank[i];
        d = eff;
        d.neg = p_neg[i];
        d.blank = p_blank[i];
        q.push_back(d);
    endtask

    initial begin
        set_plan(0, 5, 7, 2, 0, 0, 1);
        set_plan(1, 3, 9, 3, 0, 0, 1);
        set_plan(2, 0, 0, 2, 0, 0, 1);
        set_plan(3, 6, 4, 2, 1, 0, 1);
        set_plan(4, 0, 0, 0, 1, 0, 0);
        set_plan(5, 4, 4, 3, 0, 1, 1);
        set_plan(6, 0, 0, 0, 0, 1, 0);
        set_plan(7, 2, 8, 2, 1, 0, 1);
        set_plan(8, 7, 3, 4, 0, 0, 1);
        set_plan(9, 0, 0, 0, 0, 0, 0);
        set_plan(10, 1, 12, 2, 1, 0, 1);
        set_plan(11, 9, 2, 2, 0, 1, 1);
        set_plan(12, 5, 5, 2, 1, 0, 1);
        set_plan(13, 3, 0, 5, 0, 0, 1);

        apply(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 gates", {gate_fa, gate_fb, gate_sa, gate_sb}, 0);
        check("R1 strobes", {cycle_start, sample_trig}, 0);
        rst = 1'b0;
        for (int i = 1; i < NCYC; i++) begin
            do @(negedge clk); while (!cycle_start);
            apply(i);
            @(negedge clk);
            times_load = 1'b0;
            if (!p_blank[i-1]) begin
                // R9: mid-period flips of polarity and bridge-off must not act
                polarity_neg = ~p_neg[i];
                bridge_off_req = ~p_blank[i];
                @(negedge clk);
                polarity_neg = p_neg[i];
                bridge_off_req = p_blank[i];
            end
        end
    end

    // Monitor: pops one period expectation per period and compares every tick.
    initial begin
        desc_s d;
        int    len;
        int    kt;
        int    g_exp;
        int    t_exp;
        string tag;
        wait (!rst);
        for (int c = 0; c < NCYC; c++) begin
            wait (q.size() > 0);
            d = q.pop_front();
            len = d.blank ? d.dead_l : (d.on_l + d.off_l + 2 * d.dead_l);
            kt  = d.on_l + d.dead_l + d.off_l;
            tag = d.blank ? "R7" : (d.neg ? "R4" : "R3");
            for (int k = 0; k < len; k++) begin
                @(negedge clk);
                if (d.blank) begin
                    g_exp = 0;
                end else if (k < d.on_l) begin
                    g_exp = d.neg ? 4'b1001 : 4'b0110;
                end else if (k < d.on_l + d.dead_l) begin
                    g_exp = d.neg ? 4'b0001 : 4'b0010;   // R5 gap
                end else if (k < kt) begin
                    g_exp = d.neg ? 4'b0101 : 4'b1010;
                end else begin
                    g_exp = d.neg ? 4'b0001 : 4'b0010;   // R5 gap, R11 slow exclusive
                end
                t_exp = (!d.blank && k == kt) ? 1 : 0;
                check({tag, " R2 gates"}, {gate_fa, gate_fb, gate_sa, gate_sb}, g_exp);
                check("R6 trigger", sample_trig, t_exp);
                check("R10 cycle_start", cycle_start, (k == 0) ? 1 : 0);
            end
        end
        mon_done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (mon_done);
            end
            begin
                repeat (20000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule